// File: doc/BRIEF.md
# Banked Memory Decoder with Protected Base Page

This block sits between a CPU with a 16-bit address bus and a RAM that is larger than that address space. The CPU selects a bank by writing its number to an I/O port. The decoder then prepends the bank number to every CPU address to form the physical RAM address. It also drives one active-low chip-enable per bank, for systems that build each bank from its own chip, and an active-low write-enable.

The lowest page of the logical space is the one whose high address byte is zero. It holds the restart and interrupt entry code, so it always maps to bank 0, whichever bank is selected. Boot logic can raise a lock request once that page is initialised. From then until reset, writes into the page are dropped in hardware and each dropped write is reported by a single-cycle flag.

A bank change never affects an access that has already started. The new bank applies from the next access onward.

Top module: `bank_mapper`

## Requirements
- R1: After reset the selected bank is 0, `locked` is 0 and `wr_violation` is 0.
- R2: An `io_wr` cycle with `io_addr` equal to 0x7E loads the bank latch from `io_data[1:0]`. An `io_wr` to any other port address leaves the bank unchanged.
- R3: Outside the common page (`cpu_addr[15:8]` nonzero), `ram_addr` equals `{bank, cpu_addr}`, with the bank in bits 17:16.
- R4: Inside the common page (`cpu_addr[15:8]` equal to 0), `ram_addr[17:16]` is 0 whatever bank is selected.
- R5: While `mem_req` is high, exactly one bit of `ram_ce_n` is low, and it is the bit indexed by `ram_addr[17:16]`. While `mem_req` is low, all bits of `ram_ce_n` are high.
- R6: `ram_we_n` is low only when `mem_req` and `mem_we` are both high and the write is not blocked.
- R7: `lock_req` high at a clock edge sets `locked`. Once set, `locked` stays set until reset, whatever `lock_req` does.
- R8: While `locked` is 1, a write to the common page keeps `ram_we_n` high. Writes to other pages still assert it.
- R9: A blocked write raises `wr_violation` for exactly one cycle, in the cycle after the access starts.
- R10: An access is a run of consecutive `mem_req` cycles. Every cycle of an access uses the bank that was selected when it started, even if the bank port is written during the access. The next access uses the new bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O port address |
| io_data | input | 8 | I/O write data |
| lock_req | input | 1 | Boot logic request to write-protect the common page |
| mem_req | input | 1 | Memory access in progress |
| mem_we | input | 1 | Access is a write |
| cpu_addr | input | 16 | CPU logical address |
| ram_addr | output | 18 | Physical RAM address, {bank, cpu_addr} |
| ram_ce_n | output | 4 | Active-low chip enable, one per bank |
| ram_we_n | output | 1 | Active-low RAM write enable |
| wr_violation | output | 1 | One-cycle pulse for a blocked write |
| locked | output | 1 | Common-page write lock state |

## Verification
The assertions check several properties on every cycle:
- at most one chip enable is active, and it matches the address bank bits;
- common-page accesses land in bank 0;
- a locked common-page write never asserts the write enable;
- the lock never clears;
- the violation flag never lasts two cycles;
- the bank stays steady for the whole of a multi-cycle access.

Some behaviours only the bench scenarios can show. These are the exact bank decoded from the I/O data, that a write to a foreign port is ignored, and the reset values. The bench also shows that the violation appears in the right cycle and that a bank written mid-access takes effect on the following access.

// File: rtl/bank_mapper.sv
module bank_mapper #(
  parameter int AW = 16,
  parameter int BANK_W = 2,
  parameter int PAGE_W = 8,
  parameter int IO_W = 8,
  parameter logic [IO_W-1:0] BANK_PORT = 8'h7E
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 io_wr,
  input  logic [IO_W-1:0]      io_addr,
  input  logic [IO_W-1:0]      io_data,
  input  logic                 lock_req,
  input  logic                 mem_req,
  input  logic                 mem_we,
  input  logic [AW-1:0]        cpu_addr,
  output logic [AW+BANK_W-1:0] ram_addr,
  output logic [(1<<BANK_W)-1:0] ram_ce_n,
  output logic                 ram_we_n,
  output logic                 wr_violation,
  output logic                 locked
);
  localparam int NBANK = 1 << BANK_W;

  logic [BANK_W-1:0] bank_q, held_q, eff_bank, phys_bank;
  logic req_q, lock_q, viol_q;
  logic common, blocked;

  assign common    = cpu_addr[AW-1 -: PAGE_W] == '0;
  assign eff_bank  = req_q ? held_q : bank_q;
  assign phys_bank = common ? '0 : eff_bank;
  assign blocked   = lock_q && common;

  assign ram_addr     = {phys_bank, cpu_addr};
  assign ram_we_n     = !(mem_req && mem_we && !blocked);
  assign wr_violation = viol_q;
  assign locked       = lock_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_ce
    assign ram_ce_n[b] = !(mem_req && phys_bank == BANK_W'(b));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
      held_q <= '0;
      req_q  <= 1'b0;
      lock_q <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      if (io_wr && io_addr == BANK_PORT) bank_q <= io_data[BANK_W-1:0];
      held_q <= eff_bank;
      req_q  <= mem_req;
      lock_q <= lock_q | lock_req;
      viol_q <= mem_req && !req_q && mem_we && blocked;
    end
  end

  a_r5_one_chip: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ram_ce_n) && (mem_req == (ram_ce_n != '1)));
  a_r5_ce_matches_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !ram_ce_n[ram_addr[AW +: BANK_W]]);
  a_r4_common_bank0: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && cpu_addr[AW-1 -: PAGE_W] == '0) |-> ram_addr[AW +: BANK_W] == '0);
  a_r8_locked_no_we: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && cpu_addr[AW-1 -: PAGE_W] == '0) |-> ram_we_n);
  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  a_r9_viol_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_violation |=> !wr_violation);
  a_r10_bank_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && req_q && $stable(cpu_addr)) |-> $stable(ram_addr));
endmodule

// File: tb/bank_mapper_bench.sv
module bank_mapper_bench;
  logic clk = 0, rst_n = 0;
  logic io_wr = 0, lock_req = 0, mem_req = 0, mem_we = 0;
  logic [7:0] io_addr = 0, io_data = 0;
  logic [15:0] cpu_addr = 0;
  logic [17:0] ram_addr;
  logic [3:0] ram_ce_n;
  logic ram_we_n, wr_violation, locked;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  bank_mapper u_bank_mapper (.clk, .rst_n, .io_wr, .io_addr, .io_data, .lock_req,
    .mem_req, .mem_we, .cpu_addr, .ram_addr, .ram_ce_n, .ram_we_n, .wr_violation, .locked);

  localparam int NV = 6;
  localparam logic [1:0]  V_BANK [NV] = '{2'd1, 2'd3, 2'd2, 2'd2, 2'd3, 2'd0};
  localparam logic [15:0] V_ADDR [NV] = '{16'h1234, 16'hFFFF, 16'h0066, 16'h0100, 16'h00FF, 16'h8000};
  localparam logic        V_WE   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [17:0] V_RA   [NV] = '{18'h11234, 18'h3FFFF, 18'h00066, 18'h20100, 18'h000FF, 18'h08000};
  localparam logic [3:0]  V_CE   [NV] = '{4'b1101, 4'b0111, 4'b1110, 4'b1011, 4'b1110, 4'b1110};
  localparam logic        V_WEN  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(logic [7:0] port, logic [7:0] d);
    @(negedge clk); io_wr = 1; io_addr = port; io_data = d;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic start_access(logic [15:0] a, logic w);
    @(negedge clk); mem_req = 1; mem_we = w; cpu_addr = a; #1;
  endtask

  task automatic end_access();
    @(negedge clk); mem_req = 0; mem_we = 0; #1;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    start_access(16'h4000, 1'b0);
    check("R1 bank", 32'(ram_addr), 32'h04000);
    check("R1 locked", 32'(locked), 0);
    check("R1 viol", 32'(wr_violation), 0);
    end_access();
    check("R5 idle ce", 32'(ram_ce_n), 32'hF);
    check("R6 idle we", 32'(ram_we_n), 1);

    // R2 R3 R4 R5 R6 vector table
    for (int i = 0; i < NV; i++) begin
      io_write(8'h7E, {6'b101010, V_BANK[i]});
      start_access(V_ADDR[i], V_WE[i]);
      check("R3/R4 ram_addr", 32'(ram_addr), 32'(V_RA[i]));
      check("R5 ce", 32'(ram_ce_n), 32'(V_CE[i]));
      check("R6 we", 32'(ram_we_n), 32'(V_WEN[i]));
      end_access();
    end

    // R2 foreign port ignored (bank is 0 now)
    io_write(8'h7F, 8'h03);
    start_access(16'h2222, 1'b0);
    check("R2 foreign port", 32'(ram_addr), 32'h02222);
    end_access();
    io_write(8'h7E, 8'h02);

    // R7 lock, sticky
    @(negedge clk); lock_req = 1;
    @(negedge clk); lock_req = 0;
    check("R7 locked set", 32'(locked), 1);
    repeat (3) @(negedge clk);
    check("R7 locked sticky", 32'(locked), 1);

    // R8 R9 blocked write, multi-cycle
    start_access(16'h0010, 1'b1);
    check("R8 blocked we", 32'(ram_we_n), 1);
    check("R9 viol not yet", 32'(wr_violation), 0);
    @(negedge clk); #1;
    check("R9 viol pulse", 32'(wr_violation), 1);
    check("R8 still blocked", 32'(ram_we_n), 1);
    @(negedge clk); #1;
    check("R9 viol ends", 32'(wr_violation), 0);
    end_access();
    start_access(16'h0310, 1'b1);
    check("R8 other page we", 32'(ram_we_n), 0);
    check("R8 other page addr", 32'(ram_addr), 32'h20310);
    @(negedge clk); #1;
    check("R9 no viol", 32'(wr_violation), 0);
    end_access();

    // R10 bank change mid-access
    start_access(16'hA000, 1'b0);
    check("R10 start", 32'(ram_addr), 32'h2A000);
    io_addr = 8'h7E; io_data = 8'h01; io_wr = 1;
    @(negedge clk); io_wr = 0; #1;
    check("R10 held addr", 32'(ram_addr), 32'h2A000);
    check("R10 held ce", 32'(ram_ce_n), 32'hB);
    @(negedge clk); #1;
    check("R10 still held", 32'(ram_addr), 32'h2A000);
    end_access();
    start_access(16'hA000, 1'b0);
    check("R10 next access", 32'(ram_addr), 32'h1A000);
    end_access();

    // R1 R7 reset clears lock and bank
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    start_access(16'h0020, 1'b1);
    check("R1 lock cleared", 32'(locked), 0);
    check("R1 we after reset", 32'(ram_we_n), 0);
    end_access();
    start_access(16'h5555, 1'b0);
    check("R1 bank after reset", 32'(ram_addr), 32'h05555);
    end_access();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule